// File: doc/BRIEF.md
# Compare-Match Square Wave Timer

This block divides the system clock down to a square wave with a 50% duty cycle. A prescaler turns the system clock into a count tick. The tick rate is set by a clock-select register. An 8-bit up-counter advances once per tick. When the counter reaches the value in the compare register, three things happen: the counter returns to zero, an output flip-flop inverts, and the interrupt output pulses high. One half period therefore lasts N+1 ticks, and the full wave period is 2(N+1) ticks.

Software programs the block through a small write port with an address, a write strobe and a data byte. Writing the control register does the following:
- It starts or stops counting.
- It gates the flip-flop onto the output pin.
- It can preset the flip-flop high or low before counting begins.

The compare value is locked while counting runs, so the output period cannot be disturbed part-way through a half period.

Top module: `sq_timer`

## Requirements
- R1: After reset, sq_o and irq_o are 0, counting is stopped, the compare value is 0, clock select is 0 and the flip-flop is low.
- R2: No tick or match takes effect until the run bit (control bit 0) is 1. After the control write that sets run, the first output inversion appears N+1 cycles later when the divide is 1.
- R3: On the tick where the counter equals the compare value, the counter clears to 0, the flip-flop inverts, and irq_o is 1 for the following cycle. irq_o is 0 in every other cycle.
- R4: While running, each half period of the flip-flop lasts (N+1)·D system cycles, where D is the selected divide. This holds at the limits N=0 and N=255.
- R5: When the output-enable bit (control bit 1) is 0, sq_o is 0. When it is 1, sq_o follows the flip-flop.
- R6: A control write with bit 2 = 1 and bit 3 = 0 forces the flip-flop high. A control write with bit 2 = 0 and bit 3 = 1 forces it low. The new level shows in the cycle after the write, and a preset takes priority over a toggle in the same cycle.
- R7: A control write with bits 2 and 3 both 0 or both 1 leaves the flip-flop unchanged.
- R8: A write to the compare register is ignored while the run bit is 1.
- R9: While run is 0, the counter is held at 0 and the flip-flop keeps its level. Setting run again restarts the count from 0, so the first inversion comes after a full N+1 ticks.
- R10: Clock select bits [2:0] choose the divide: codes 0 to 6 give divide-by 2^code, and code 7 gives divide-by 256. Data bits [7:3] of that write are ignored.
- R11: Addresses select the registers as 0 for compare, 1 for clock select and 2 for control. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| sq_o | output | 1 | Square-wave output |
| irq_o | output | 1 | One-cycle match pulse |

## Verification
Two situations are hard to reach from the ports. One is a compare write that lands while counting runs. The other is proving that the flip-flop froze rather than just toggling too slowly to notice. The stimulus writes a new compare value in the middle of a run and then measures the next half period, which must still reflect the old value. It then stops the timer, waits far longer than any half period, and confirms that the output has not moved. After that it loads a new compare value and measures the delay from the restart to the first edge, which shows that the counter restarted from zero. The divide codes are swept one by one against the half-period formula, including the jump from divide-by-64 to divide-by-256.

// File: rtl/sq_timer_pkg.sv
package sq_timer_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMP  = 2'd0,
    REG_CLK  = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_OE  = 1;
  localparam int unsigned CTRL_SET = 2;
  localparam int unsigned CTRL_CLR = 3;

  // top code selects the widest prescale, otherwise 2^code
  function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel, input int unsigned top);
    if (&sel) return top;
    return 32'(sel);
  endfunction
endpackage

// File: rtl/sq_timer_regs.sv
module sq_timer_regs
  import sq_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              run_o,
  output logic              oe_o,
  output logic              preset_vld_o,
  output logic              preset_lvl_o
);
  logic wr_cmp, wr_clk, wr_ctrl;
  logic [CNT_W-1:0] cmp_q;
  logic [SEL_W-1:0] sel_q;
  logic run_q, oe_q;
  logic unused_wdata;

  assign wr_cmp  = wr_en_i && (addr_i == REG_CMP);
  assign wr_clk  = wr_en_i && (addr_i == REG_CLK);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_CLR+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      sel_q <= '0;
      run_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      // compare is locked while counting
      if (wr_cmp && !run_q) cmp_q <= wdata_i[CNT_W-1:0];
      if (wr_clk)           sel_q <= wdata_i[SEL_W-1:0];
      if (wr_ctrl) begin
        run_q <= wdata_i[CTRL_RUN];
        oe_q  <= wdata_i[CTRL_OE];
      end
    end
  end

  // set/clear bits act only at write time; equal pair is a no-op
  assign preset_vld_o = wr_ctrl && (wdata_i[CTRL_SET] != wdata_i[CTRL_CLR]);
  assign preset_lvl_o = wdata_i[CTRL_SET];

  assign cmp_o = cmp_q;
  assign sel_o = sel_q;
  assign run_o = run_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/sq_timer_prescaler.sv
module sq_timer_prescaler
  import sq_timer_pkg::*;
#(
  parameter int unsigned PS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PS_W-1:0] pcnt_q, mask;
  int unsigned shift;

  assign shift = div_shift(sel_i, PS_W);

  for (genvar b = 0; b < PS_W; b++) begin : g_mask
    assign mask[b] = (b < shift);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + PS_W'(1);
  end

  assign tick_o = run_i && ((pcnt_q & mask) == mask);
endmodule

// File: rtl/sq_timer_core.sv
module sq_timer_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             preset_vld_i,
  input  logic             preset_lvl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ff_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic ff_q, irq_q, hit;

  assign hit = run_i && tick_i && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ff_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (!run_i)      cnt_q <= '0;
      else if (hit)    cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
      if (preset_vld_i) ff_q <= preset_lvl_i;
      else if (hit)     ff_q <= ~ff_q;
    end
  end

  assign cnt_o = cnt_q;
  assign ff_o  = ff_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/sq_timer.sv
module sq_timer
  import sq_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sq_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cmp_val, cnt_val;
  logic [SEL_W-1:0] sel_val;
  logic run_q, oe_q, tick, out_ff, preset_vld, preset_lvl;

  sq_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cmp_o(cmp_val), .sel_o(sel_val), .run_o(run_q), .oe_o(oe_q),
    .preset_vld_o(preset_vld), .preset_lvl_o(preset_lvl)
  );

  sq_timer_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i, .rst_ni, .run_i(run_q), .sel_i(sel_val), .tick_o(tick)
  );

  sq_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .run_i(run_q), .tick_i(tick), .cmp_i(cmp_val),
    .preset_vld_i(preset_vld), .preset_lvl_i(preset_lvl),
    .cnt_o(cnt_val), .ff_o(out_ff), .irq_o(irq_o)
  );

  assign sq_o = oe_q & out_ff;
endmodule

// File: rtl/sq_timer_chk.sv
module sq_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ff_i,
  input logic             irq_i,
  input logic             preset_vld_i,
  input logic             preset_lvl_i
);
  a_r8_cmp_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> $stable(cmp_i));

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_i <= cmp_i);

  a_r9_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_i == '0);

  a_r3_irq_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !$past(preset_vld_i)) |-> ff_i != $past(ff_i));

  a_r6_preset_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_vld_i |=> ff_i == $past(preset_lvl_i));

  a_r2_irq_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(run_i));
endmodule

bind sq_timer sq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .cmp_i(cmp_val),
  .cnt_i(cnt_val), .ff_i(out_ff), .irq_i(irq_o),
  .preset_vld_i(preset_vld), .preset_lvl_i(preset_lvl)
);

// File: tb/sq_timer_bench.sv
module sq_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic sq, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sq_timer u_sq_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .sq_o(sq), .irq_o(irq)
  );

  // behavioural reference
  int m_cmp, m_sel, m_pcnt, m_cnt;
  bit m_run, m_oe, m_ff, m_irq;

  function automatic int divof(int s);
    return (s == 7) ? 256 : (1 << s);
  endfunction

  always @(posedge clk) begin : model
    bit t, nirq;
    if (!rst_n) begin
      m_cmp = 0; m_sel = 0; m_pcnt = 0; m_cnt = 0;
      m_run = 0; m_oe = 0; m_ff = 0; m_irq = 0;
    end else begin
      nirq = 0;
      if (m_run) begin
        t = (m_pcnt % divof(m_sel)) == divof(m_sel) - 1;
        m_pcnt = (m_pcnt + 1) % 256;
        if (t) begin
          if (m_cnt == m_cmp) begin m_cnt = 0; m_ff = !m_ff; nirq = 1; end
          else m_cnt = m_cnt + 1;
        end
      end else begin
        m_pcnt = 0; m_cnt = 0;
      end
      if (wr_en) begin
        if (addr == 0 && !m_run) m_cmp = wdata;
        if (addr == 1) m_sel = wdata & 7;
        if (addr == 2) begin
          m_run = wdata[0]; m_oe = wdata[1];
          if (wdata[2] != wdata[3]) m_ff = wdata[2];
        end
      end
      m_irq = nirq;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 irq vs model", irq, m_irq);
      check("R5 sq vs model", sq, m_oe ? m_ff : 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic half(output int c);
    logic p;
    int k;
    p = sq; k = 0;
    while (sq == p && k < 2000) begin @(negedge clk); k++; end
    p = sq; c = 0;
    while (sq == p && c < 2000) begin @(negedge clk); c++; end
  endtask

  task automatic latency(output int k);
    logic p;
    p = sq; k = 0;
    while (sq == p && k < 2000) begin @(negedge clk); k++; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    int c, s;
    repeat (3) @(negedge clk);
    check("R1 reset sq", sq, 0);
    check("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 idle irq", irq, 0);
    check("R1 idle sq", sq, 0);

    wr(0, 3); wr(2, 'h03);
    latency(c); check("R2 start latency", c, 4);
    half(c); check("R4 half period N=3", c, 4);

    wr(0, 9);
    half(c); check("R8 compare write ignored while running", c, 4);

    wr(2, 'h02);
    s = sq;
    repeat (30) @(negedge clk);
    check("R9 frozen level", sq, s);
    check("R9 no irq while stopped", irq, 0);
    wr(0, 9); wr(2, 'h03);
    latency(c); check("R9 restart from zero", c, 10);
    wr(2, 'h02);

    wr(2, 'h06); check("R6 preset high", sq, 1);
    wr(2, 'h0A); check("R6 preset low", sq, 0);
    wr(2, 'h06); wr(2, 'h0E); check("R7 both bits set no change", sq, 1);
    wr(2, 'h02); check("R7 both bits clear no change", sq, 1);

    wr(2, 'h04); check("R5 output disabled", sq, 0);
    wr(2, 'h02); check("R5 output enabled shows ff", sq, 1);
    wr(0, 1); wr(2, 'h01);
    repeat (20) @(negedge clk);
    check("R5 disabled while running", sq, 0);
    wr(2, 'h02);

    for (int k = 0; k < 8; k++) begin
      wr(0, 2); wr(1, k | 'hF8); wr(2, 'h03);
      half(c); check($sformatf("R10 divide code %0d", k), c, 3 * divof(k));
      wr(2, 'h02);
    end

    wr(1, 0); wr(0, 0); wr(2, 'h03);
    half(c); check("R4 boundary N=0", c, 1);
    wr(2, 'h02); wr(0, 255); wr(1, 1); wr(2, 'h03);
    half(c); check("R4 boundary N=255 div2", c, 512);
    wr(2, 'h02);

    s = sq;
    wr(3, 'hFF);
    repeat (5) @(negedge clk);
    check("R11 addr3 no effect on output", sq, s);
    wr(1, 0); wr(0, 5); wr(3, 0); wr(2, 'h03);
    half(c); check("R11 addr3 leaves compare and clock", c, 6);
    wr(2, 'h02);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule